// File: doc/BRIEF.md
# Two-Slot Reorder Buffer with Slot-Index Renaming

This block holds in-flight instructions for a core that decodes one instruction per cycle and may issue them out of program order. Each instruction takes a reorder-buffer slot when it is decoded, and the slot number is the name it is known by. A mapping table records, for every architectural register, whether its newest value is still being produced, and if so by which slot. Register sources are resolved when the instruction is decoded. An operand can be taken from the architectural register file, from a slot that has already produced its result, or from the result being broadcast in that same cycle. If none of these applies, the operand waits on the producing slot's number.

One ready instruction is issued per cycle, and the one that has been in the buffer longest is chosen. Execution is modelled by a per-slot latency counter. The result is the sum of the first source and either the second source or the immediate. When its counter runs out, a slot broadcasts its number and result on the single writeback port, and waiting operands capture the value. Slots retire in program order to the architectural register file, at the earliest one cycle after writeback. A freed slot number is handed out again straight away.

Top module: `rob_rename_core`

## Requirements
- R1: After reset the buffer is empty, `dec_ready` is 1, and `iss_valid`, `wb_valid` and `cmt_valid` are all 0. All architectural registers read as zero.
- R2: Accepted decodes receive slot numbers 0, 1, 0, 1, … in acceptance order. A slot number is reused once the instruction holding it has retired.
- R3: While every slot is occupied, `dec_ready` is 0 and an instruction offered on `dec_valid` is not accepted: it never issues and never retires.
- R4: At most one instruction issues per cycle. An instruction whose operands are all known at decode issues in the cycle after decode, and ready instructions issue in the order they entered the buffer.
- R5: An instruction issued in cycle i with latency L (0 is treated as 1) writes back in cycle i+L. When two slots finish in the same cycle, the older one writes back first and the other follows in the next cycle.
- R6: A slot retires no earlier than the cycle after its writeback, and retirement follows program order. A slot that finishes early waits for every older slot to retire first.
- R7: The result is src1 + (`dec_src2_imm` ? `dec_imm` : src2), modulo 2^DATA_W. Each register source is read in one of three ways: from the register file when no slot is producing it, from a finished slot, or by waiting for the producer's writeback. A waiting instruction can issue no earlier than the cycle after that writeback.
- R8: When a slot retires, the mapping for its destination is cleared only if it still names that slot. A later instruction that reads a register rewritten by a younger pending slot receives the younger value.
- R9: Retirement presents the slot number, destination and result on the `cmt_*` outputs and writes the result into the architectural register file. An instruction with `dec_dst_en` = 0 retires with `cmt_dst_en` = 0 and leaves the mapping table and the register file untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_ready | output | 1 | A slot is free; the offer is taken at the clock edge |
| dec_tag | output | TAG_W | Slot number the offered instruction receives |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_dst | input | AREG_W | Destination register |
| dec_src1 | input | AREG_W | First source register |
| dec_src2 | input | AREG_W | Second source register |
| dec_src2_imm | input | 1 | Use `dec_imm` in place of the second source |
| dec_imm | input | DATA_W | Immediate operand |
| dec_lat | input | LAT_W | Execution latency in cycles |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_tag | output | TAG_W | Slot that issues |
| wb_valid | output | 1 | A result is broadcast this cycle |
| wb_tag | output | TAG_W | Slot that writes back |
| wb_data | output | DATA_W | Broadcast result |
| cmt_valid | output | 1 | The oldest slot retires this cycle |
| cmt_tag | output | TAG_W | Retiring slot |
| cmt_dst_en | output | 1 | Retiring instruction writes a register |
| cmt_dst | output | AREG_W | Retiring destination register |
| cmt_data | output | DATA_W | Retiring result |

## Verification
The assertions assume that `dec_valid` and the decode fields change only between clock edges. They also assume that decode offers are counted as accepted only when `dec_ready` is high, and that the offered latency fits in LAT_W. The bench drives every decode field on the falling edge and holds it until an accepting edge. It deliberately keeps `dec_valid` high across stalled cycles, and uses only non-zero latencies, so overlapping writebacks come from real timing and not from a degenerate encoding. Register r0 is never written, so it serves as a constant zero source.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2,
    SLOT_DONE = 2'd3
  } slot_state_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rob_age_pick.sv
// Picks the first requester at or after base, wrapping round N slots.
module rob_age_pick #(
  parameter int unsigned N  = 2,
  parameter int unsigned IW = 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] pick
);

  logic [31:0] cand;

  always_comb begin
    found = 1'b0;
    pick  = base;
    cand  = '0;
    for (int unsigned k = 0; k < N; k++) begin
      cand = 32'(base) + k;
      if (cand >= N) cand = cand - N;
      if (!found && req[cand[IW-1:0]]) begin
        found = 1'b1;
        pick  = cand[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/rob_map_table.sv
// Architectural register -> producing slot map.
module rob_map_table #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned AW       = 3,
  parameter int unsigned TW       = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd1_reg,
  output logic          rd1_busy,
  output logic [TW-1:0] rd1_tag,
  input  logic [AW-1:0] rd2_reg,
  output logic          rd2_busy,
  output logic [TW-1:0] rd2_tag,
  input  logic          set_en,
  input  logic [AW-1:0] set_reg,
  input  logic [TW-1:0] set_tag,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_reg,
  input  logic [TW-1:0] clr_tag
);

  logic          busy_q [NUM_ARCH];
  logic [TW-1:0] tag_q  [NUM_ARCH];
  logic          busy_d [NUM_ARCH];
  logic [TW-1:0] tag_d  [NUM_ARCH];

  assign rd1_busy = busy_q[rd1_reg];
  assign rd1_tag  = tag_q[rd1_reg];
  assign rd2_busy = busy_q[rd2_reg];
  assign rd2_tag  = tag_q[rd2_reg];

  always_comb begin
    for (int r = 0; r < NUM_ARCH; r++) begin
      busy_d[r] = busy_q[r];
      tag_d[r]  = tag_q[r];
    end
    // conditional clear first; a same-cycle rename of that register wins
    if (clr_en && busy_q[clr_reg] && (tag_q[clr_reg] == clr_tag))
      busy_d[clr_reg] = 1'b0;
    if (set_en) begin
      busy_d[set_reg] = 1'b1;
      tag_d[set_reg]  = set_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ARCH; r++) begin
        busy_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_ARCH; r++) begin
        busy_q[r] <= busy_d[r];
        tag_q[r]  <= tag_d[r];
      end
    end
  end

endmodule

// File: rtl/rob_arch_regs.sv
// Committed architectural register file: two reads, one write.
module rob_arch_regs #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned AW       = 3,
  parameter int unsigned DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd1_reg,
  output logic [DW-1:0] rd1_val,
  input  logic [AW-1:0] rd2_reg,
  output logic [DW-1:0] rd2_val,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_reg,
  input  logic [DW-1:0] wr_val
);

  logic [DW-1:0] mem_q [NUM_ARCH];

  assign rd1_val = mem_q[rd1_reg];
  assign rd2_val = mem_q[rd2_reg];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ARCH; r++) mem_q[r] <= '0;
    end else if (wr_en) begin
      mem_q[wr_reg] <= wr_val;
    end
  end

endmodule

// File: rtl/rob_rename_core.sv
module rob_rename_core
  import rob_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 2,
  parameter int unsigned NUM_ARCH    = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LAT_W       = 4,
  localparam int unsigned TAG_W      = rob_pkg::idx_bits(NUM_ENTRIES),
  localparam int unsigned AREG_W     = rob_pkg::idx_bits(NUM_ARCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  output logic [TAG_W-1:0]  dec_tag,
  input  logic              dec_dst_en,
  input  logic [AREG_W-1:0] dec_dst,
  input  logic [AREG_W-1:0] dec_src1,
  input  logic [AREG_W-1:0] dec_src2,
  input  logic              dec_src2_imm,
  input  logic [DATA_W-1:0] dec_imm,
  input  logic [LAT_W-1:0]  dec_lat,
  output logic              iss_valid,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data,
  output logic              cmt_valid,
  output logic [TAG_W-1:0]  cmt_tag,
  output logic              cmt_dst_en,
  output logic [AREG_W-1:0] cmt_dst,
  output logic [DATA_W-1:0] cmt_data
);

  localparam logic [TAG_W-1:0] LAST_SLOT = TAG_W'(NUM_ENTRIES - 1);

  // ---------------- reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // ---------------- slot storage
  slot_state_e       st_q    [NUM_ENTRIES];
  logic              a_rdy_q [NUM_ENTRIES];
  logic [TAG_W-1:0]  a_tag_q [NUM_ENTRIES];
  logic [DATA_W-1:0] a_val_q [NUM_ENTRIES];
  logic              b_rdy_q [NUM_ENTRIES];
  logic [TAG_W-1:0]  b_tag_q [NUM_ENTRIES];
  logic [DATA_W-1:0] b_val_q [NUM_ENTRIES];
  logic              dst_en_q[NUM_ENTRIES];
  logic [AREG_W-1:0] dst_q   [NUM_ENTRIES];
  logic [LAT_W-1:0]  lat_q   [NUM_ENTRIES];
  logic [LAT_W-1:0]  cnt_q   [NUM_ENTRIES];
  logic [DATA_W-1:0] res_q   [NUM_ENTRIES];

  slot_state_e       st_d    [NUM_ENTRIES];
  logic              a_rdy_d [NUM_ENTRIES];
  logic [TAG_W-1:0]  a_tag_d [NUM_ENTRIES];
  logic [DATA_W-1:0] a_val_d [NUM_ENTRIES];
  logic              b_rdy_d [NUM_ENTRIES];
  logic [TAG_W-1:0]  b_tag_d [NUM_ENTRIES];
  logic [DATA_W-1:0] b_val_d [NUM_ENTRIES];
  logic              dst_en_d[NUM_ENTRIES];
  logic [AREG_W-1:0] dst_d   [NUM_ENTRIES];
  logic [LAT_W-1:0]  lat_d   [NUM_ENTRIES];
  logic [LAT_W-1:0]  cnt_d   [NUM_ENTRIES];
  logic [DATA_W-1:0] res_d   [NUM_ENTRIES];

  logic [TAG_W-1:0] head_q, tail_q, head_d, tail_d;
  logic             full_q, full_d;

  function automatic logic [TAG_W-1:0] slot_inc(input logic [TAG_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + TAG_W'(1);
  endfunction

  // ---------------- control
  logic alloc, cmt_fire;
  assign dec_ready = !full_q && rst_sync_n;
  assign alloc     = dec_valid && dec_ready;
  assign cmt_fire  = (st_q[head_q] == SLOT_DONE);

  logic [NUM_ENTRIES-1:0] iss_req, wb_req;
  logic                   iss_fire, wb_fire;
  logic [TAG_W-1:0]       iss_pick, wb_pick;
  logic [DATA_W-1:0]      wb_val;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_req
    assign iss_req[g] = (st_q[g] == SLOT_WAIT) && a_rdy_q[g] && b_rdy_q[g];
    assign wb_req[g]  = (st_q[g] == SLOT_EXEC) && (cnt_q[g] == '0);
  end

  rob_age_pick #(.N(NUM_ENTRIES), .IW(TAG_W)) u_issue_pick (
    .req(iss_req), .base(head_q), .found(iss_fire), .pick(iss_pick)
  );

  rob_age_pick #(.N(NUM_ENTRIES), .IW(TAG_W)) u_wb_pick (
    .req(wb_req), .base(head_q), .found(wb_fire), .pick(wb_pick)
  );

  assign wb_val = res_q[wb_pick];

  // ---------------- rename table and committed registers
  logic              m1_busy, m2_busy;
  logic [TAG_W-1:0]  m1_tag, m2_tag;
  logic [DATA_W-1:0] rf1_val, rf2_val;

  rob_map_table #(.NUM_ARCH(NUM_ARCH), .AW(AREG_W), .TW(TAG_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd1_reg  (dec_src1),
    .rd1_busy (m1_busy),
    .rd1_tag  (m1_tag),
    .rd2_reg  (dec_src2),
    .rd2_busy (m2_busy),
    .rd2_tag  (m2_tag),
    .set_en   (alloc && dec_dst_en),
    .set_reg  (dec_dst),
    .set_tag  (tail_q),
    .clr_en   (cmt_fire && dst_en_q[head_q]),
    .clr_reg  (dst_q[head_q]),
    .clr_tag  (head_q)
  );

  rob_arch_regs #(.NUM_ARCH(NUM_ARCH), .AW(AREG_W), .DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd1_reg (dec_src1),
    .rd1_val (rf1_val),
    .rd2_reg (dec_src2),
    .rd2_val (rf2_val),
    .wr_en   (cmt_fire && dst_en_q[head_q]),
    .wr_reg  (dst_q[head_q]),
    .wr_val  (res_q[head_q])
  );

  // ---------------- operand resolution at decode
  logic              op1_rdy, op2_rdy;
  logic [TAG_W-1:0]  op1_tag, op2_tag;
  logic [DATA_W-1:0] op1_val, op2_val;

  always_comb begin
    op1_rdy = 1'b1;
    op1_tag = m1_tag;
    op1_val = rf1_val;
    if (m1_busy) begin
      if (st_q[m1_tag] == SLOT_DONE) begin
        op1_val = res_q[m1_tag];
      end else if (wb_fire && (wb_pick == m1_tag)) begin
        op1_val = wb_val;
      end else begin
        op1_rdy = 1'b0;
        op1_val = '0;
      end
    end

    op2_rdy = 1'b1;
    op2_tag = m2_tag;
    op2_val = rf2_val;
    if (dec_src2_imm) begin
      op2_val = dec_imm;
    end else if (m2_busy) begin
      if (st_q[m2_tag] == SLOT_DONE) begin
        op2_val = res_q[m2_tag];
      end else if (wb_fire && (wb_pick == m2_tag)) begin
        op2_val = wb_val;
      end else begin
        op2_rdy = 1'b0;
        op2_val = '0;
      end
    end
  end

  // ---------------- slot next state
  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      st_d[e]     = st_q[e];
      a_rdy_d[e]  = a_rdy_q[e];
      a_tag_d[e]  = a_tag_q[e];
      a_val_d[e]  = a_val_q[e];
      b_rdy_d[e]  = b_rdy_q[e];
      b_tag_d[e]  = b_tag_q[e];
      b_val_d[e]  = b_val_q[e];
      dst_en_d[e] = dst_en_q[e];
      dst_d[e]    = dst_q[e];
      lat_d[e]    = lat_q[e];
      cnt_d[e]    = cnt_q[e];
      res_d[e]    = res_q[e];
      unique case (st_q[e])
        SLOT_FREE: begin
          if (alloc && (tail_q == TAG_W'(e))) begin
            st_d[e]     = SLOT_WAIT;
            a_rdy_d[e]  = op1_rdy;
            a_tag_d[e]  = op1_tag;
            a_val_d[e]  = op1_val;
            b_rdy_d[e]  = op2_rdy;
            b_tag_d[e]  = op2_tag;
            b_val_d[e]  = op2_val;
            dst_en_d[e] = dec_dst_en;
            dst_d[e]    = dec_dst;
            lat_d[e]    = dec_lat;
          end
        end
        SLOT_WAIT: begin
          if (wb_fire && !a_rdy_q[e] && (a_tag_q[e] == wb_pick)) begin
            a_rdy_d[e] = 1'b1;
            a_val_d[e] = wb_val;
          end
          if (wb_fire && !b_rdy_q[e] && (b_tag_q[e] == wb_pick)) begin
            b_rdy_d[e] = 1'b1;
            b_val_d[e] = wb_val;
          end
          if (iss_fire && (iss_pick == TAG_W'(e))) begin
            st_d[e]  = SLOT_EXEC;
            cnt_d[e] = (lat_q[e] == '0) ? '0 : lat_q[e] - LAT_W'(1);
            res_d[e] = a_val_q[e] + b_val_q[e];
          end
        end
        SLOT_EXEC: begin
          if (wb_fire && (wb_pick == TAG_W'(e))) begin
            st_d[e] = SLOT_DONE;
          end else if (cnt_q[e] != '0) begin
            cnt_d[e] = cnt_q[e] - LAT_W'(1);
          end
        end
        SLOT_DONE: begin
          if (cmt_fire && (head_q == TAG_W'(e))) st_d[e] = SLOT_FREE;
        end
        default: st_d[e] = SLOT_FREE;
      endcase
    end
  end

  // ---------------- pointer next state
  always_comb begin
    tail_d = alloc    ? slot_inc(tail_q) : tail_q;
    head_d = cmt_fire ? slot_inc(head_q) : head_q;
    full_d = full_q;
    if (alloc && !cmt_fire)      full_d = (slot_inc(tail_q) == head_q);
    else if (cmt_fire && !alloc) full_d = 1'b0;
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      head_q <= '0;
      tail_q <= '0;
      full_q <= 1'b0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        st_q[e]     <= SLOT_FREE;
        a_rdy_q[e]  <= 1'b0;
        a_tag_q[e]  <= '0;
        a_val_q[e]  <= '0;
        b_rdy_q[e]  <= 1'b0;
        b_tag_q[e]  <= '0;
        b_val_q[e]  <= '0;
        dst_en_q[e] <= 1'b0;
        dst_q[e]    <= '0;
        lat_q[e]    <= '0;
        cnt_q[e]    <= '0;
        res_q[e]    <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        st_q[e]     <= st_d[e];
        a_rdy_q[e]  <= a_rdy_d[e];
        a_tag_q[e]  <= a_tag_d[e];
        a_val_q[e]  <= a_val_d[e];
        b_rdy_q[e]  <= b_rdy_d[e];
        b_tag_q[e]  <= b_tag_d[e];
        b_val_q[e]  <= b_val_d[e];
        dst_en_q[e] <= dst_en_d[e];
        dst_q[e]    <= dst_d[e];
        lat_q[e]    <= lat_d[e];
        cnt_q[e]    <= cnt_d[e];
        res_q[e]    <= res_d[e];
      end
    end
  end

  // ---------------- outputs
  assign dec_tag    = tail_q;
  assign iss_valid  = iss_fire;
  assign iss_tag    = iss_pick;
  assign wb_valid   = wb_fire;
  assign wb_tag     = wb_pick;
  assign wb_data    = wb_val;
  assign cmt_valid  = cmt_fire;
  assign cmt_tag    = head_q;
  assign cmt_dst_en = dst_en_q[head_q];
  assign cmt_dst    = dst_q[head_q];
  assign cmt_data   = res_q[head_q];

endmodule

// File: rtl/rob_rename_core_chk.sv
module rob_rename_core_chk #(
  parameter int unsigned NUM_ENTRIES = 2,
  localparam int unsigned TAG_W      = rob_pkg::idx_bits(NUM_ENTRIES),
  localparam int unsigned OCC_W      = $clog2(NUM_ENTRIES + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic [TAG_W-1:0] dec_tag,
  input logic             iss_valid,
  input logic [TAG_W-1:0] iss_tag,
  input logic             wb_valid,
  input logic [TAG_W-1:0] wb_tag,
  input logic             cmt_valid,
  input logic [TAG_W-1:0] cmt_tag
);

  localparam logic [TAG_W-1:0] LAST = TAG_W'(NUM_ENTRIES - 1);

  logic [OCC_W-1:0]       occ_q;
  logic [TAG_W-1:0]       exp_tail_q, exp_head_q;
  logic [NUM_ENTRIES-1:0] live_q, issued_q, written_q;
  logic                   fire;

  assign fire = dec_valid && dec_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q      <= '0;
      exp_tail_q <= '0;
      exp_head_q <= '0;
      live_q     <= '0;
      issued_q   <= '0;
      written_q  <= '0;
    end else begin
      occ_q <= occ_q + OCC_W'(fire) - OCC_W'(cmt_valid);
      if (fire)      exp_tail_q <= (exp_tail_q == LAST) ? '0 : exp_tail_q + TAG_W'(1);
      if (cmt_valid) exp_head_q <= (exp_head_q == LAST) ? '0 : exp_head_q + TAG_W'(1);
      if (cmt_valid) begin
        live_q[cmt_tag]    <= 1'b0;
        issued_q[cmt_tag]  <= 1'b0;
        written_q[cmt_tag] <= 1'b0;
      end
      if (fire)      live_q[dec_tag]   <= 1'b1;
      if (iss_valid) issued_q[iss_tag] <= 1'b1;
      if (wb_valid)  written_q[wb_tag] <= 1'b1;
    end
  end

  assert_idle_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0) |-> (!iss_valid && !wb_valid && !cmt_valid));

  assert_tag_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (dec_tag == exp_tail_q));

  assert_stall_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OCC_W'(NUM_ENTRIES)) |-> !dec_ready);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(NUM_ENTRIES));

  assert_issue_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (live_q[iss_tag] && !issued_q[iss_tag]));

  assert_wb_after_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (issued_q[wb_tag] && !written_q[wb_tag]));

  assert_commit_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> ((cmt_tag == exp_head_q) && written_q[cmt_tag]));

endmodule

bind rob_rename_core rob_rename_core_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (.*);

// File: tb/rob_rename_core_tb.sv
module rob_rename_core_tb;

  localparam int NE = 2;
  localparam int DW = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_valid, dec_dst_en, dec_src2_imm;
  logic        dec_ready;
  logic [0:0]  dec_tag, iss_tag, wb_tag, cmt_tag;
  logic [2:0]  dec_dst, dec_src1, dec_src2, cmt_dst;
  logic [15:0] dec_imm, wb_data, cmt_data;
  logic [3:0]  dec_lat;
  logic        iss_valid, wb_valid, cmt_valid, cmt_dst_en;

  always #5 clk = ~clk;

  rob_rename_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_tag(dec_tag),
    .dec_dst_en(dec_dst_en), .dec_dst(dec_dst), .dec_src1(dec_src1),
    .dec_src2(dec_src2), .dec_src2_imm(dec_src2_imm), .dec_imm(dec_imm),
    .dec_lat(dec_lat),
    .iss_valid(iss_valid), .iss_tag(iss_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_dst_en(cmt_dst_en),
    .cmt_dst(cmt_dst), .cmt_data(cmt_data)
  );

  typedef struct {
    int tag;
    bit en;
    int dst;
    int data;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  int   cyc = 0;
  int   alloc_cnt = 0;
  int   last_dec_cyc, last_tag;
  int   regs_m [8];
  int   iss_cyc [NE], wb_cyc [NE], cmt_cyc [NE];
  bit   done = 1'b0;
  int   lcg = 32'h1234_5679;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: event timing and retirement scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (iss_valid) iss_cyc[iss_tag] = cyc;
      if (wb_valid)  wb_cyc[wb_tag]   = cyc;
      if (cmt_valid) begin
        exp_t e;
        cmt_cyc[cmt_tag] = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "retirement with nothing expected (tag)", int'(cmt_tag), -1);
        end else begin
          e = exp_q.pop_front();
          chk(int'(cmt_tag) == e.tag, "R6", "retire slot order", int'(cmt_tag), e.tag);
          chk(cmt_dst_en == e.en, "R9", "retire dest enable", int'(cmt_dst_en), int'(e.en));
          if (e.en) chk(int'(cmt_dst) == e.dst, "R9", "retire dest reg", int'(cmt_dst), e.dst);
          chk(int'(cmt_data) == e.data, "R7", "retire result", int'(cmt_data), e.data);
        end
      end
    end
  end

  // driver: called at a falling edge, returns at a falling edge with dec_valid low
  task automatic decode(input bit den, input int dst, input int s1, input int s2,
                        input bit use_imm, input int imm, input int lat);
    exp_t e;
    dec_valid    = 1'b1;
    dec_dst_en   = den;
    dec_dst      = 3'(dst);
    dec_src1     = 3'(s1);
    dec_src2     = 3'(s2);
    dec_src2_imm = use_imm;
    dec_imm      = 16'(imm);
    dec_lat      = 4'(lat);
    while (!dec_ready) @(negedge clk);
    chk(int'(dec_tag) == alloc_cnt % NE, "R2", "slot number at decode", int'(dec_tag), alloc_cnt % NE);
    e.tag  = alloc_cnt % NE;
    e.en   = den;
    e.dst  = dst;
    e.data = (regs_m[s1] + (use_imm ? (imm & 16'hFFFF) : regs_m[s2])) & 16'hFFFF;
    if (den) regs_m[dst] = e.data;
    exp_q.push_back(e);
    last_dec_cyc = cyc;
    last_tag     = e.tag;
    alloc_cnt++;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int rnd(input int m);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 8) & 32'h7FFF) % m;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d0, t0, t1;
    for (int r = 0; r < 8; r++) regs_m[r] = 0;
    dec_valid = 0; dec_dst_en = 0; dec_dst = 0; dec_src1 = 0; dec_src2 = 0;
    dec_src2_imm = 0; dec_imm = 0; dec_lat = 1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(dec_ready == 1'b1, "R1", "dec_ready after reset", int'(dec_ready), 1);
    chk(iss_valid == 1'b0, "R1", "iss_valid after reset", int'(iss_valid), 0);
    chk(wb_valid == 1'b0, "R1", "wb_valid after reset", int'(wb_valid), 0);
    chk(cmt_valid == 1'b0, "R1", "cmt_valid after reset", int'(cmt_valid), 0);

    // R4/R5/R6: single instruction timing, r1 = r0 + 5, latency 3
    decode(1, 1, 0, 0, 1, 5, 3);
    d0 = last_dec_cyc; t0 = last_tag;
    drain();
    chk(iss_cyc[t0] == d0 + 1, "R4", "issue cycle after decode", iss_cyc[t0], d0 + 1);
    chk(wb_cyc[t0] - iss_cyc[t0] == 3, "R5", "latency issue to writeback", wb_cyc[t0] - iss_cyc[t0], 3);
    chk(cmt_cyc[t0] - wb_cyc[t0] == 1, "R6", "writeback to retire", cmt_cyc[t0] - wb_cyc[t0], 1);

    // R5 writeback collision: older slot wins, younger next cycle
    decode(1, 2, 1, 0, 1, 1, 5);   // r2 = r1 + 1 = 6
    t0 = last_tag;
    decode(1, 3, 0, 0, 1, 2, 4);   // r3 = 2
    t1 = last_tag;
    drain();
    chk(wb_cyc[t0] - iss_cyc[t0] == 5, "R5", "older latency", wb_cyc[t0] - iss_cyc[t0], 5);
    chk(wb_cyc[t1] == wb_cyc[t0] + 1, "R5", "younger writeback deferred", wb_cyc[t1], wb_cyc[t0] + 1);
    chk(iss_cyc[t1] == iss_cyc[t0] + 1, "R4", "issue one per cycle in order", iss_cyc[t1], iss_cyc[t0] + 1);
    chk(cmt_cyc[t1] == cmt_cyc[t0] + 1, "R6", "retire in program order", cmt_cyc[t1], cmt_cyc[t0] + 1);

    // R3 full stall + R8 conditional map clear + R7 wakeup
    decode(1, 4, 0, 0, 1, 7, 1);   // r4 = 7, finishes early
    decode(1, 4, 0, 0, 1, 9, 10);  // r4 = 9, long
    t0 = last_tag;
    chk(dec_ready == 1'b0, "R3", "dec_ready with all slots taken", int'(dec_ready), 0);
    dec_valid = 1'b1; dec_dst_en = 1'b1; dec_dst = 3'd7; dec_src1 = 3'd0;
    dec_src2_imm = 1'b1; dec_imm = 16'd99; dec_lat = 4'd1;
    @(negedge clk);
    chk(dec_ready == 1'b0, "R3", "still stalled", int'(dec_ready), 0);
    @(negedge clk);
    dec_valid = 1'b0;
    decode(1, 5, 4, 0, 1, 1, 1);   // r5 = r4 + 1 = 10 (younger value)
    t1 = last_tag;
    drain();
    chk(iss_cyc[t1] == wb_cyc[t0] + 1, "R7", "waiting operand issues after wakeup", iss_cyc[t1], wb_cyc[t0] + 1);

    // R7 finished-slot source and register src2, R9 no-destination retire
    decode(1, 6, 0, 0, 1, 3, 8);   // r6 = 3, slow head
    decode(1, 7, 0, 0, 1, 4, 1);   // r7 = 4, finishes behind head
    decode(1, 1, 7, 6, 0, 0, 2);   // r1 = r7 + r6 = 7
    decode(0, 0, 7, 0, 1, 0, 1);   // no destination, result 4
    decode(1, 2, 1, 5, 0, 0, 1);   // r2 = r1 + r5 = 17
    drain();

    // mixed stream
    for (int i = 0; i < 40; i++) begin
      int s2i;
      s2i = rnd(2);
      decode(rnd(5) != 0, 1 + rnd(7), rnd(8), rnd(8), s2i[0], rnd(256), 1 + rnd(6));
    end
    drain();
    chk(exp_q.size() == 0, "R6", "all expected retirements seen", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule